// File: doc/BRIEF.md
# Message-Signalled Interrupt Capability Registers

This block is the register window of a message-signalled interrupt capability. Software reaches it through a byte-addressed port. Reads always return a 32-bit word. Writes are either 16 or 32 bits wide. The window holds the following:

- a header made of a fixed identifier and a next-pointer;
- a message-control half-word;
- a message address of one or two words;
- a message data word;
- an optional per-vector mask word.

Where the data and mask words sit depends on two build-time capability settings: wide (64-bit) addressing and per-vector masking. The block reports the resulting structure length on a port.

From the stored state the block derives one result per vector, for up to 32 vectors:

- an active flag;
- the shared 64-bit message address;
- a data word, formed from the message data with the vector index ORed into it.

The delivery logic downstream reads these per-vector results. The next-pointer comes from an input, so whoever places capabilities in the list sets it.

Top module: `msi_cap_regs`

## Requirements
- R1: Reset clears the enable, the multi-message enable, the extended-data enable and the address, data and mask registers. While reset is held and afterwards, every vector is inactive until software enables the block.
- R2: Word 0 reads back with the layout {control[15:0], next_ptr[7:0], 8'h05}. In the control half-word, bit 0 is enable and bits 3:1 are the multi-message capability. Bits 6:4 are the multi-message enable and bit 7 is the wide-address capability. Bit 8 is the mask capability, bit 9 the extended-data capability and bit 10 the extended-data enable. Bits 15:11 read zero.
- R3: cap_len equals 12, plus 4 when wide addressing is built in, plus 8 when masking is built in.
- R4: The low address sits at byte 0x4. With wide addressing, the high address is at 0x8, the data at 0xC and the mask at 0x10. Without it, the data is at 0x8 and the mask at 0xC. The read word index is the byte offset divided by 4. Unused words read zero.
- R5: Control is written by a 2-byte write at offset 0x2, or by a 4-byte write at offset 0x0 that takes its upper half. The multi-message enable changes only if the old or the new enable bit is clear. It then takes the smaller of the written field and the capability field.
- R6: The extended-data enable is stored only when extended data is built in. Otherwise it stays 0.
- R7: A 2-byte data write replaces only bits 15:0. A 4-byte data write replaces all 32 bits only when extended data is built in. Otherwise it too replaces only bits 15:0.
- R8: Vector i is active only if enable is set, i < 2^(multi-message enable), and mask bit i is clear. Mask bits count only when masking is built in.
- R9: Every vector sees the same address: {high, low} with wide addressing, else {32'h0, low}. Vector i's data is the stored data, cut to 16 bits unless extended data is enabled, ORed with i.
- R10: While enable is clear, all vectors are inactive.
- R11: A write at any offset and size combination not listed in R4 and R5 changes no register. This includes the mask and high-address words when their capability is absent.
- R12: The vector outputs show the effect of a register write one clock after the edge that stores the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per access |
| wr_offset | input | 5 | Byte offset of the write |
| wr_wide | input | 1 | 1 = 4-byte write, 0 = 2-byte write (data in bits 15:0) |
| wr_data | input | 32 | Write value |
| rd_index | input | 3 | Word index of the read (byte offset / 4) |
| rd_data | output | 32 | Read word, combinational |
| next_ptr | input | 8 | Next-pointer value shown in byte 1 |
| cap_len | output | 8 | Structure length in bytes |
| vec_active | output | NUM_VEC | Per-vector active flags |
| vec_addr | output | 64 | Message address shared by all vectors |
| vec_data | output | NUM_VEC*32 | Per-vector data, vector i in bits [32i+31:32i] |

## Verification
The multi-message enable decides how many vectors can fire. If it is held wrongly, word 0 reads back wrong at once, and vec_active has the wrong population count one cycle after the write. If a write lands in the wrong register because of a layout decode error, the readback sweep shows it within eight cycles. Data truncation that does not follow the extended-data settings shows in every vector's data word one cycle later. Two builds with different layouts see the same write stream, so a write that one build should ignore but stores is caught against the other's expected values.

// File: rtl/msi_cap_pkg.sv
`timescale 1ns/1ps
package msi_cap_pkg;

  typedef struct packed {
    logic       ext_en;
    logic [2:0] mme;
    logic       en;
  } msi_ctrl_t;

  localparam logic [7:0] MSI_CAP_ID = 8'h05;

  function automatic logic [2:0] clamp_mme(input logic [2:0] req, input logic [2:0] cap);
    return (req > cap) ? cap : req;
  endfunction

  function automatic logic [7:0] msi_len(input bit wide, input bit pvm);
    return 8'd12 + (wide ? 8'd4 : 8'd0) + (pvm ? 8'd8 : 8'd0);
  endfunction

endpackage

// File: rtl/msi_ctrl_reg.sv
`timescale 1ns/1ps
module msi_ctrl_reg
  import msi_cap_pkg::*;
#(
  parameter int unsigned MMC_CAP = 5,
  parameter bit          EXT_CAP = 1'b1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ctrl_we,
  input  msi_ctrl_t ctrl_wr,
  output msi_ctrl_t ctrl_q
);

  localparam logic [2:0] MMC = 3'(MMC_CAP);

  msi_ctrl_t ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (!ctrl_q.en || !ctrl_wr.en) begin
      ctrl_d.mme = clamp_mme(ctrl_wr.mme, MMC);
    end
    ctrl_d.ext_en = EXT_CAP && ctrl_wr.ext_en;
    ctrl_d.en     = ctrl_wr.en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_we) begin
      ctrl_q <= ctrl_d;
    end
  end

  AST_MME_FROZEN_WHILE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && ctrl_q.en && ctrl_wr.en) |=> $stable(ctrl_q.mme)); // R5

  AST_MME_WITHIN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> (ctrl_q.mme <= MMC)); // R5

endmodule

// File: rtl/msi_msg_regs.sv
`timescale 1ns/1ps
module msi_msg_regs
  import msi_cap_pkg::*;
#(
  parameter bit ADDR64   = 1'b1,
  parameter bit MASK_CAP = 1'b1,
  parameter bit EXT_CAP  = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [4:0]  wr_offset,
  input  logic        wr_wide,
  input  logic [31:0] wr_data,
  output logic        ctrl_we,
  output msi_ctrl_t   ctrl_wr,
  output logic [31:0] addr_lo,
  output logic [31:0] addr_hi,
  output logic [31:0] msg_data,
  output logic [31:0] vec_mask
);

  localparam logic [4:0]  OFS_LO    = 5'h04;
  localparam logic [4:0]  OFS_HI    = 5'h08;
  localparam logic [4:0]  OFS_DATA  = ADDR64 ? 5'h0C : 5'h08;
  localparam logic [4:0]  OFS_MASK  = ADDR64 ? 5'h10 : 5'h0C;
  localparam logic [31:0] WIDE_KEEP = EXT_CAP ? 32'hFFFF_FFFF : 32'h0000_FFFF;

  logic        hit_lo, hit_hi, hit_data, hit_mask, wr_hit;
  logic [31:0] data_keep, data_d;

  always_comb begin
    ctrl_we  = wr_en && (((wr_offset == 5'h02) && !wr_wide) ||
                         ((wr_offset == 5'h00) && wr_wide));
    hit_lo   = wr_en && wr_wide && (wr_offset == OFS_LO);
    hit_hi   = wr_en && wr_wide && ADDR64 && (wr_offset == OFS_HI);
    hit_data = wr_en && (wr_offset == OFS_DATA);
    hit_mask = wr_en && wr_wide && MASK_CAP && (wr_offset == OFS_MASK);
    wr_hit   = ctrl_we || hit_lo || hit_hi || hit_data || hit_mask;

    ctrl_wr.en     = wr_wide ? wr_data[16] : wr_data[0];
    ctrl_wr.mme    = wr_wide ? wr_data[22:20] : wr_data[6:4];
    ctrl_wr.ext_en = wr_wide ? wr_data[26] : wr_data[10];

    data_keep = wr_wide ? WIDE_KEEP : 32'h0000_FFFF;
    data_d    = (msg_data & ~data_keep) | (wr_data & data_keep);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_lo <= '0;
    end else if (hit_lo) begin
      addr_lo <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_hi <= '0;
    end else if (hit_hi) begin
      addr_hi <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_data <= '0;
    end else if (hit_data) begin
      msg_data <= data_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_mask <= '0;
    end else if (hit_mask) begin
      vec_mask <= wr_data;
    end
  end

  AST_HALF_WRITE_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_wide) |=> $stable(msg_data[31:16])); // R7

  AST_IGNORED_WRITE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_hit) |=> ($stable(addr_lo) && $stable(addr_hi) &&
                            $stable(msg_data) && $stable(vec_mask))); // R11

endmodule

// File: rtl/msi_vec_gen.sv
`timescale 1ns/1ps
module msi_vec_gen
  import msi_cap_pkg::*;
#(
  parameter int unsigned NUM_VEC = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  msi_ctrl_t               ctrl,
  input  logic [63:0]             msg_addr,
  input  logic [31:0]             msg_data,
  input  logic [NUM_VEC-1:0]      vec_mask,
  output logic [NUM_VEC-1:0]      vec_active,
  output logic [63:0]             vec_addr,
  output logic [NUM_VEC*32-1:0]   vec_data
);

  logic [31:0]           msg_eff;
  logic [7:0]            vec_lim;
  logic [NUM_VEC-1:0]    act_d;
  logic [NUM_VEC*32-1:0] dat_d;

  always_comb begin
    msg_eff = ctrl.ext_en ? msg_data : {16'h0000, msg_data[15:0]};
    vec_lim = 8'd1 << ctrl.mme;
  end

  for (genvar i = 0; i < NUM_VEC; i++) begin : g_vec
    always_comb begin
      act_d[i]          = ctrl.en && (8'(i) < vec_lim) && !vec_mask[i];
      dat_d[i*32 +: 32] = msg_eff | 32'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_active <= '0;
      vec_addr   <= '0;
      vec_data   <= '0;
    end else begin
      vec_active <= act_d;
      vec_addr   <= msg_addr;
      vec_data   <= dat_d;
    end
  end

  AST_OFF_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.en |=> (vec_active == '0)); // R10

  AST_MASKED_NEVER_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_active & $past(vec_mask)) == '0); // R8

endmodule

// File: rtl/msi_cap_regs.sv
`timescale 1ns/1ps
module msi_cap_regs
  import msi_cap_pkg::*;
#(
  parameter int unsigned MMC_CAP  = 5,
  parameter bit          ADDR64   = 1'b1,
  parameter bit          MASK_CAP = 1'b1,
  parameter bit          EXT_CAP  = 1'b1,
  localparam int unsigned NUM_VEC = 1 << MMC_CAP
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [4:0]            wr_offset,
  input  logic                  wr_wide,
  input  logic [31:0]           wr_data,
  input  logic [2:0]            rd_index,
  output logic [31:0]           rd_data,
  input  logic [7:0]            next_ptr,
  output logic [7:0]            cap_len,
  output logic [NUM_VEC-1:0]    vec_active,
  output logic [63:0]           vec_addr,
  output logic [NUM_VEC*32-1:0] vec_data
);

  localparam logic [7:0] LEN = msi_len(ADDR64, MASK_CAP);

  msi_ctrl_t   ctrl_q, ctrl_wr;
  logic        ctrl_we;
  logic [31:0] addr_lo, addr_hi, msg_data, vec_mask;
  logic [63:0] msg_addr;
  logic [15:0] ctrl16;

  msi_msg_regs #(
    .ADDR64  (ADDR64),
    .MASK_CAP(MASK_CAP),
    .EXT_CAP (EXT_CAP)
  ) u_msg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_offset(wr_offset),
    .wr_wide  (wr_wide),
    .wr_data  (wr_data),
    .ctrl_we  (ctrl_we),
    .ctrl_wr  (ctrl_wr),
    .addr_lo  (addr_lo),
    .addr_hi  (addr_hi),
    .msg_data (msg_data),
    .vec_mask (vec_mask)
  );

  msi_ctrl_reg #(
    .MMC_CAP(MMC_CAP),
    .EXT_CAP(EXT_CAP)
  ) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctrl_we(ctrl_we),
    .ctrl_wr(ctrl_wr),
    .ctrl_q (ctrl_q)
  );

  always_comb begin
    msg_addr = ADDR64 ? {addr_hi, addr_lo} : {32'h0000_0000, addr_lo};
    ctrl16   = {5'b00000, ctrl_q.ext_en, EXT_CAP, MASK_CAP, ADDR64,
                ctrl_q.mme, 3'(MMC_CAP), ctrl_q.en};
    cap_len  = LEN;
    case (rd_index)
      3'd0:    rd_data = {ctrl16, next_ptr, MSI_CAP_ID};
      3'd1:    rd_data = addr_lo;
      3'd2:    rd_data = ADDR64 ? addr_hi : msg_data;
      3'd3:    rd_data = ADDR64 ? msg_data : (MASK_CAP ? vec_mask : 32'h0);
      3'd4:    rd_data = (ADDR64 && MASK_CAP) ? vec_mask : 32'h0;
      default: rd_data = 32'h0;
    endcase
  end

  msi_vec_gen #(
    .NUM_VEC(NUM_VEC)
  ) u_vec (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl      (ctrl_q),
    .msg_addr  (msg_addr),
    .msg_data  (msg_data),
    .vec_mask  (vec_mask[NUM_VEC-1:0]),
    .vec_active(vec_active),
    .vec_addr  (vec_addr),
    .vec_data  (vec_data)
  );

endmodule

// File: tb/msi_cap_regs_test.sv
`timescale 1ns/1ps
module msi_cap_regs_test;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, wr_en, wr_wide;
  logic [4:0]    wr_offset;
  logic [31:0]   wr_data;
  logic [2:0]    rd_index;
  logic [7:0]    next_ptr;

  logic [31:0]   rd0, rd1;
  logic [7:0]    len0, len1;
  logic [31:0]   act0;
  logic [3:0]    act1;
  logic [63:0]   addr0, addr1;
  logic [1023:0] dat0;
  logic [127:0]  dat1;

  // wide layout, 32 vectors, extended data
  msi_cap_regs #(.MMC_CAP(5), .ADDR64(1'b1), .MASK_CAP(1'b1), .EXT_CAP(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_offset(wr_offset), .wr_wide(wr_wide),
    .wr_data(wr_data), .rd_index(rd_index), .rd_data(rd0), .next_ptr(next_ptr),
    .cap_len(len0), .vec_active(act0), .vec_addr(addr0), .vec_data(dat0));

  // narrow layout, 4 vectors, no extended data
  msi_cap_regs #(.MMC_CAP(2), .ADDR64(1'b0), .MASK_CAP(1'b1), .EXT_CAP(1'b0)) uut_n (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_offset(wr_offset), .wr_wide(wr_wide),
    .wr_data(wr_data), .rd_index(rd_index), .rd_data(rd1), .next_ptr(next_ptr),
    .cap_len(len1), .vec_active(act1), .vec_addr(addr1), .vec_data(dat1));

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  // behavioural model state, index 0 = uut, 1 = uut_n
  int unsigned c_mmc [2] = '{5, 2};
  bit          c_a64 [2] = '{1'b1, 1'b0};
  bit          c_pvm [2] = '{1'b1, 1'b1};
  bit          c_ext [2] = '{1'b1, 1'b0};
  bit          m_en  [2];
  bit [2:0]    m_mme [2];
  bit          m_ext [2];
  bit [31:0]   m_lo [2], m_hi [2], m_dat [2], m_msk [2];
  logic [31:0]   e_act  [2];
  logic [63:0]   e_addr [2];
  logic [1023:0] e_dat  [2];

  task automatic chk(input string req, input logic [1023:0] a, input logic [1023:0] e);
    n_chk++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, a, e);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  function automatic logic [31:0] mread(input int k, input logic [2:0] w);
    logic [15:0] c;
    c = {5'b0, m_ext[k], c_ext[k], c_pvm[k], c_a64[k], m_mme[k], 3'(c_mmc[k]), m_en[k]};
    case (w)
      3'd0:    return {c, next_ptr, 8'h05};
      3'd1:    return m_lo[k];
      3'd2:    return c_a64[k] ? m_hi[k] : m_dat[k];
      3'd3:    return c_a64[k] ? m_dat[k] : (c_pvm[k] ? m_msk[k] : 32'h0);
      3'd4:    return (c_a64[k] && c_pvm[k]) ? m_msk[k] : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  task automatic predict(input int k);
    int nv;
    bit [31:0] msg;
    nv = 1 << c_mmc[k];
    msg = m_ext[k] ? m_dat[k] : (m_dat[k] & 32'h0000_FFFF);
    e_act[k] = '0;
    e_dat[k] = '0;
    for (int i = 0; i < nv; i++) begin
      e_act[k][i] = m_en[k] && (i < (1 << m_mme[k])) && !(c_pvm[k] && m_msk[k][i]);
      e_dat[k][i*32 +: 32] = msg | 32'(i);
    end
    e_addr[k] = c_a64[k] ? {m_hi[k], m_lo[k]} : {32'h0, m_lo[k]};
  endtask

  task automatic apply_wr(input int k);
    bit [15:0] nc;
    bit [31:0] keep;
    int unsigned dofs, mofs;
    dofs = c_a64[k] ? 12 : 8;
    mofs = c_a64[k] ? 16 : 12;
    if ((wr_offset == 5'h02 && !wr_wide) || (wr_offset == 5'h00 && wr_wide)) begin
      nc = wr_wide ? wr_data[31:16] : wr_data[15:0];
      if (!m_en[k] || !nc[0])
        m_mme[k] = (int'(nc[6:4]) > int'(c_mmc[k])) ? 3'(c_mmc[k]) : nc[6:4];
      m_ext[k] = c_ext[k] && nc[10];
      m_en[k]  = nc[0];
    end else if (wr_offset == 5'h04 && wr_wide) begin
      m_lo[k] = wr_data;
    end else if (wr_offset == 5'h08 && wr_wide && c_a64[k]) begin
      m_hi[k] = wr_data;
    end else if (int'(wr_offset) == dofs) begin
      keep = (wr_wide && c_ext[k]) ? 32'hFFFF_FFFF : 32'h0000_FFFF;
      m_dat[k] = (m_dat[k] & ~keep) | (wr_data & keep);
    end else if (c_pvm[k] && wr_wide && int'(wr_offset) == mofs) begin
      m_msk[k] = wr_data;
    end
  endtask

  // model: outputs follow the registers one clock later (R12)
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 2; k++) begin
        m_en[k] = 0; m_mme[k] = 0; m_ext[k] = 0;
        m_lo[k] = 0; m_hi[k] = 0; m_dat[k] = 0; m_msk[k] = 0;
        e_act[k] = '0; e_addr[k] = '0; e_dat[k] = '0;
      end
    end else begin
      for (int k = 0; k < 2; k++) begin
        predict(k);
        if (wr_en) apply_wr(k);
      end
    end
  end

  always @(negedge clk) begin
    if (cyc > 0) begin
      chk("R1 R8 R10 active wide", {992'h0, act0}, {992'h0, e_act[0]});
      chk("R1 R8 R10 active narrow", {1020'h0, act1}, {1020'h0, e_act[1][3:0]});
      chk("R4 R9 address wide", {960'h0, addr0}, {960'h0, e_addr[0]});
      chk("R4 R9 address narrow", {960'h0, addr1}, {960'h0, e_addr[1]});
      chk("R7 R9 R12 data wide", dat0, e_dat[0]);
      chk("R7 R9 R12 data narrow", {896'h0, dat1}, {896'h0, e_dat[1][127:0]});
      chk("R3 length wide", {1016'h0, len0}, 1024'd24);
      chk("R3 length narrow", {1016'h0, len1}, 1024'd20);
      chk("R2 R4 R5 R6 R11 read wide", {992'h0, rd0}, {992'h0, mread(0, rd_index)});
      chk("R2 R4 R5 R6 R11 read narrow", {992'h0, rd1}, {992'h0, mread(1, rd_index)});
    end
    rd_index = rd_index + 3'd1;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
      summary();
      $finish;
    end
  end

  task automatic wr(input logic [4:0] ofs, input logic wide, input logic [31:0] val);
    @(negedge clk);
    wr_en = 1'b1; wr_offset = ofs; wr_wide = wide; wr_data = val;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_offset = '0; wr_wide = 1'b0; wr_data = '0;
    rd_index = '0; next_ptr = 8'h48;
    idle(3);
    rst_n = 1'b1;                       // R1 reset state swept by reads
    idle(8);
    wr(5'h04, 1'b1, 32'hFEE0_1008);     // R4 low address
    wr(5'h08, 1'b1, 32'h0000_0001);     // R4 high address / narrow data (R7)
    wr(5'h0C, 1'b1, 32'hABCD_5670);     // wide data, narrow mask
    wr(5'h10, 1'b1, 32'h0000_0024);     // R11 narrow has nothing at 0x10
    idle(2);
    wr(5'h02, 1'b0, 32'h0000_0451);     // R5 R6 enable, mme 5 clamped to 2 on narrow
    idle(8);
    wr(5'h02, 1'b0, 32'h0000_0021);     // R5 mme frozen while enable stays set
    idle(3);
    wr(5'h0C, 1'b0, 32'hFFFF_1357);     // R7 half data write; R11 narrow mask needs 4 bytes
    wr(5'h08, 1'b0, 32'h0000_BEEF);     // R7 narrow half data; R11 wide ignores
    idle(2);
    wr(5'h0C, 1'b1, 32'h0000_0003);     // R8 narrow masks vectors 0 and 1
    wr(5'h10, 1'b1, 32'hFFFF_FFF0);     // R8 wide mask
    idle(3);
    wr(5'h00, 1'b1, 32'h0000_0000);     // R10 disable through 4-byte control write
    idle(3);
    wr(5'h00, 1'b1, 32'h0431_00AA);     // R5 R6 enable, mme 3, extended data
    wr(5'h10, 1'b1, 32'h0000_0000);
    wr(5'h0C, 1'b1, 32'h8765_4321);     // R7 full word only with extended data
    idle(3);
    wr(5'h06, 1'b0, 32'h1111_1111);     // R11 unlisted offsets and sizes
    wr(5'h14, 1'b1, 32'h2222_2222);
    wr(5'h04, 1'b0, 32'h3333_3333);
    wr(5'h01, 1'b1, 32'h4444_4444);
    wr(5'h10, 1'b0, 32'h5555_5555);
    idle(3);
    wr(5'h02, 1'b0, 32'h0000_0470);     // R5 disable with mme 7, clamped
    wr(5'h02, 1'b0, 32'h0000_0071);     // R5 re-enable, old enable clear
    next_ptr = 8'h60;                   // R2 next-pointer follows input
    idle(10);
    @(posedge clk);
    #2 rst_n = 1'b0;                    // R1 reset while enabled
    idle(2);
    rst_n = 1'b1;
    idle(8);
    summary();
    $finish;
  end

endmodule